// File: doc/BRIEF.md
# Windowed Peak Scaler Bank

This block sits behind a stacked discriminator with sixteen comparators. It reads the comparator outputs as a thermometer-style vector and also takes a separate low-threshold trigger. When the trigger rises, the block opens a measurement window whose length is set by an input. During the window it follows the highest comparator level that is reached. When the window closes, the block reduces that peak to one of eight bins and adds one to the 16-bit scaler of that bin.

Each scaler has a sticky overflow flag. A single jam strobe moves every scaler and its flag into a holding buffer and clears the scalers in the same clock. If a count lands on the same clock as the jam, it is not lost: it becomes the first count of the new accumulation period. The holding buffers are read through a plain combinational read port, selected by an address.

Top module: `peak_scaler_bank`

## Requirements
- R1: After reset, every holding buffer reads 0 with its overflow flag clear, and every scaler starts at 0.
- R2: The level of an input vector is the index of its highest set bit, where bit k set means comparator k has tripped. A vector with no bit set has level 0. Vectors that are not clean thermometer codes follow the same rule.
- R3: A window opens on a clock where `trig_in` is 1 after it was 0 on the previous clock, with no window already open. The window length is sampled from `win_len` on that clock, and a value of 0 counts as 1. The window covers that many clocks, starting with the trigger clock. The peak is the maximum level over those clocks.
- R4: On the last clock of a window, exactly one scaler increments by one. Its index is the peak level shifted right by one bit, so levels 2b and 2b+1 go to scaler b.
- R5: A new rise of `trig_in` while a window is open does not restart the window and does not add a count. Holding `trig_in` high after a window closes does not open another window.
- R6: A clock with `jam_in` high copies all eight scaler values and overflow flags into the holding buffers. On the same clock it clears every scaler and flag. The buffers keep their values until the next jam.
- R7: If a window closes on a jam clock, the buffer receives the value from before that count, and the target scaler restarts at 1.
- R8: An increment from 0xFFFF wraps the scaler to 0 and sets its overflow flag. The flag stays set through further counts until the next jam, which copies it into the buffer.
- R9: `rd_data` and `rd_ovf` show, combinationally, the holding buffer and buffered flag selected by `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thermo_in | input | 16 | Comparator outputs; bit k set means level k reached |
| trig_in | input | 1 | Low-threshold comparator; a rise opens a window |
| win_len | input | 8 | Window length in clocks, sampled when a window opens (0 acts as 1) |
| jam_in | input | 1 | Snapshot all scalers into the buffers and clear them |
| rd_addr | input | 3 | Buffer select for the read port |
| rd_data | output | 16 | Selected buffered count |
| rd_ovf | output | 1 | Selected buffered overflow flag |

## Verification
The hardest state to reach is the overflow wrap. A scaler only sets its flag after 65536 closed windows, and every window needs one clock with the trigger low before the next rise. The stimulus therefore runs a tight directed loop: one-clock windows at level 0, with the trigger toggling every clock, for 65538 events. After that, a jam shows the wrapped count together with the sticky flag. The remaining cases use randomized window lengths and level patterns, and add directed jams that land on the closing clock and trigger re-rises inside an open window.

// File: rtl/psb_pkg.sv
package psb_pkg;

  localparam int DEF_LEVELS   = 16;
  localparam int DEF_SCALERS  = 8;
  localparam int DEF_CNT_W    = 16;
  localparam int DEF_WIN_W    = 8;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

endpackage

// File: rtl/psb_window.sv
module psb_window
  import psb_pkg::*;
#(
  parameter int LEVELS = DEF_LEVELS,
  parameter int WIN_W  = DEF_WIN_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] thermo,
  input  logic              trig,
  input  logic [WIN_W-1:0]  win_len,
  output logic              fire,
  output logic [LVL_W-1:0]  fire_lvl,
  output logic              win_open
);

  // Highest tripped comparator; nothing tripped gives level 0.
  function automatic logic [LVL_W-1:0] top_level(input logic [LEVELS-1:0] t);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (t[i]) r = LVL_W'(i);
    end
    return r;
  endfunction

  function automatic logic [LVL_W-1:0] lvl_max(input logic [LVL_W-1:0] a,
                                               input logic [LVL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  win_state_e       state;
  logic             trig_q;
  logic             rise;
  logic [WIN_W-1:0] remain;
  logic [WIN_W-1:0] len_eff;
  logic [LVL_W-1:0] peak;
  logic [LVL_W-1:0] lvl_now;

  assign rise     = trig & ~trig_q;
  assign len_eff  = (win_len == '0) ? WIN_W'(1) : win_len;
  assign lvl_now  = top_level(thermo);
  assign win_open = (state == WIN_OPEN);

  always_comb begin
    fire     = 1'b0;
    fire_lvl = lvl_now;
    if (state == WIN_IDLE) begin
      fire = rise && (len_eff == WIN_W'(1));
    end else begin
      fire_lvl = lvl_max(peak, lvl_now);
      fire     = (remain == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= WIN_IDLE;
      trig_q <= 1'b0;
      remain <= '0;
      peak   <= '0;
    end else begin
      trig_q <= trig;
      if (state == WIN_IDLE) begin
        if (rise && (len_eff != WIN_W'(1))) begin
          state  <= WIN_OPEN;
          remain <= len_eff - WIN_W'(2);
          peak   <= lvl_now;
        end
      end else begin
        peak <= lvl_max(peak, lvl_now);
        if (remain == '0) begin
          state <= WIN_IDLE;
        end else begin
          remain <= remain - WIN_W'(1);
        end
      end
    end
  end

  // R5: an open window only counts down; a new rise cannot reload it
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_OPEN && remain != '0) |=>
      (state == WIN_OPEN && remain == $past(remain) - WIN_W'(1)));

  // R3: the window closes on the clock after its final sample
  p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_OPEN && fire) |=> (state == WIN_IDLE));

  // R3: the tracked peak never falls inside a window
  p_peak_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WIN_OPEN && remain != '0) |=> (peak >= $past(peak)));

endmodule

// File: rtl/psb_scaler.sv
module psb_scaler
  import psb_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             jam,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  // Returns {carry, sum} for a one-step increment.
  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] c);
    return {1'b0, c} + (CNT_W+1)'(1);
  endfunction

  logic [CNT_W:0] nxt;
  assign nxt = step(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (jam) begin
      cnt <= inc ? CNT_W'(1) : '0;
      ovf <= 1'b0;
    end else if (inc) begin
      cnt <= nxt[CNT_W-1:0];
      ovf <= ovf | nxt[CNT_W];
    end
  end

  // R4: without an increment or jam the count is frozen
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam && !inc) |=> ($stable(cnt) && $stable(ovf)));

  // R6: a jam leaves at most the coincident count behind
  p_jam_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jam |=> (!ovf && cnt <= CNT_W'(1)));

  // R8: the flag is sticky between jams
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !jam) |=> ovf);

  // R8: full count plus one wraps to zero and flags
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !jam && (&cnt)) |=> (cnt == '0 && ovf));

endmodule

// File: rtl/peak_scaler_bank.sv
module peak_scaler_bank
  import psb_pkg::*;
#(
  parameter int LEVELS    = DEF_LEVELS,
  parameter int N_SCALERS = DEF_SCALERS,
  parameter int CNT_W     = DEF_CNT_W,
  parameter int WIN_W     = DEF_WIN_W,
  localparam int LVL_W    = $clog2(LEVELS),
  localparam int SEL_W    = $clog2(N_SCALERS),
  localparam int SHIFT    = LVL_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] thermo_in,
  input  logic              trig_in,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              jam_in,
  input  logic [SEL_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_ovf
);

  // Drop the low level bits so adjacent level pairs share a scaler.
  function automatic logic [SEL_W-1:0] level_to_bin(input logic [LVL_W-1:0] l);
    return SEL_W'(l >> SHIFT);
  endfunction

  logic                 fire;
  logic [LVL_W-1:0]     fire_lvl;
  logic                 win_open;
  logic [SEL_W-1:0]     bin;
  logic [N_SCALERS-1:0] inc;
  logic [N_SCALERS-1:0] sc_ovf;
  logic [CNT_W-1:0]     sc_cnt  [N_SCALERS];
  logic [CNT_W-1:0]     hold_cnt[N_SCALERS];
  logic [N_SCALERS-1:0] hold_ovf;

  psb_window #(
    .LEVELS (LEVELS),
    .WIN_W  (WIN_W)
  ) i_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .thermo   (thermo_in),
    .trig     (trig_in),
    .win_len  (win_len),
    .fire     (fire),
    .fire_lvl (fire_lvl),
    .win_open (win_open)
  );

  assign bin = level_to_bin(fire_lvl);

  for (genvar g = 0; g < N_SCALERS; g++) begin : g_sc
    assign inc[g] = fire && (bin == SEL_W'(g));

    psb_scaler #(
      .CNT_W (CNT_W)
    ) i_scaler (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc[g]),
      .jam   (jam_in),
      .cnt   (sc_cnt[g]),
      .ovf   (sc_ovf[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_cnt[g] <= '0;
        hold_ovf[g] <= 1'b0;
      end else if (jam_in) begin
        hold_cnt[g] <= sc_cnt[g];
        hold_ovf[g] <= sc_ovf[g];
      end
    end
  end

  assign rd_data = hold_cnt[rd_addr];
  assign rd_ovf  = hold_ovf[rd_addr];

  // R4: a closing window hits exactly one scaler, nothing else does
  p_one_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(inc) == 1));

  p_no_stray_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (inc == '0));

  // R6: buffered flags only change on a jam
  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !jam_in |=> $stable(hold_ovf));

  // R6: a jam copies the live flags
  p_buf_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jam_in |=> (hold_ovf == $past(sc_ovf)));

endmodule

// File: tb/test_peak_scaler_bank.sv
`timescale 1ns/1ps
module test_peak_scaler_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] thermo_in;
  logic        trig_in;
  logic [7:0]  win_len;
  logic        jam_in;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        rd_ovf;

  always #2.5 clk = ~clk;

  peak_scaler_bank i_peak_scaler_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .thermo_in (thermo_in),
    .trig_in   (trig_in),
    .win_len   (win_len),
    .jam_in    (jam_in),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_ovf    (rd_ovf)
  );

  int          errors = 0;
  int          checks = 0;
  int unsigned exp_cnt [8];
  bit          exp_ovf [8];
  int unsigned exp_buf [8];
  bit          exp_bovf[8];

  function automatic int top_bit(logic [15:0] t);
    int r = 0;
    for (int i = 0; i < 16; i++) if (t[i]) r = i;
    return r;
  endfunction

  function automatic logic [15:0] thermo_of(int k);
    return 16'((32'h1 << (k + 1)) - 1);
  endfunction

  task automatic model_count(int lvl);
    int b = lvl / 2;
    exp_cnt[b] = exp_cnt[b] + 1;
    if (exp_cnt[b] == 65536) begin
      exp_cnt[b] = 0;
      exp_ovf[b] = 1'b1;
    end
  endtask

  task automatic model_jam();
    for (int i = 0; i < 8; i++) begin
      exp_buf[i]  = exp_cnt[i];
      exp_bovf[i] = exp_ovf[i];
      exp_cnt[i]  = 0;
      exp_ovf[i]  = 1'b0;
    end
  endtask

  task automatic check_bufs(string tag);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      rd_addr = 3'(a);
      #1;
      checks++;
      if (rd_data !== 16'(exp_buf[a]) || rd_ovf !== exp_bovf[a]) begin
        errors++;
        $display("FAIL %s addr %0d data=%h ovf=%b expected data=%h ovf=%b",
                 tag, a, rd_data, rd_ovf, 16'(exp_buf[a]), exp_bovf[a]);
      end
    end
  endtask

  task automatic do_jam();
    @(negedge clk);
    jam_in = 1'b1;
    @(negedge clk);
    jam_in = 1'b0;
    model_jam();
  endtask

  // One window: len samples (0 acts as 1); optional jam on last sample,
  // optional re-rise inside the window and trigger held after it.
  task automatic run_event(int len, bit jam_last, bit retrig, bit garbage);
    int eff = (len == 0) ? 1 : len;
    int pk  = 0;
    logic [15:0] pat;
    for (int s = 0; s < eff; s++) begin
      @(negedge clk);
      if (garbage) pat = 16'($urandom);
      else if ($urandom % 8 == 0) pat = 16'h0;
      else pat = thermo_of($urandom % 16);
      thermo_in = pat;
      if (top_bit(pat) > pk) pk = top_bit(pat);
      trig_in = (retrig && s == 1) ? 1'b0 : 1'b1;
      win_len = (s == 0) ? 8'(len) : 8'($urandom % 8);
      jam_in  = jam_last && (s == eff - 1);
    end
    if (retrig) begin
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        trig_in = 1'b1;
        jam_in  = 1'b0;
        thermo_in = 16'hFFFF;
      end
    end
    @(negedge clk);
    trig_in = 1'b0;
    jam_in = 1'b0;
    thermo_in = 16'h0;
    if (jam_last) model_jam();
    model_count(pk);
  endtask

  initial begin
    #(190000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; thermo_in = '0; trig_in = 0; win_len = 8'd1;
    jam_in = 0; rd_addr = '0;
    for (int i = 0; i < 8; i++) begin
      exp_cnt[i] = 0; exp_ovf[i] = 0; exp_buf[i] = 0; exp_bovf[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9: reset state through the read port
    check_bufs("R1 R9");

    // R3 R4: random levels and window lengths (0..7)
    for (int n = 0; n < 200; n++) run_event($urandom % 8, 0, 0, 0);
    do_jam();
    check_bufs("R3 R4 R6");

    // R2: non-thermometer patterns use the highest set bit
    for (int n = 0; n < 60; n++) run_event(1 + $urandom % 4, 0, 0, 1);
    do_jam();
    check_bufs("R2");

    // R5: re-rise inside the window and trigger held afterwards
    for (int n = 0; n < 20; n++) run_event(3 + $urandom % 4, 0, 1, 0);
    do_jam();
    check_bufs("R5");

    // R7: window closing on the jam clock
    for (int n = 0; n < 10; n++) begin
      run_event($urandom % 3, 0, 0, 0);
      run_event(1 + $urandom % 4, 1, 0, 0);
      check_bufs("R7 pre-count snapshot");
      do_jam();
      check_bufs("R7 count restarts at 1");
    end

    // R8: 65538 one-clock level-0 windows wrap scaler 0
    do_jam();
    for (int n = 0; n < 65538; n++) begin
      @(negedge clk);
      trig_in = 1'b1; thermo_in = 16'h0; win_len = 8'd1;
      @(negedge clk);
      trig_in = 1'b0;
      model_count(0);
    end
    do_jam();
    check_bufs("R8 wrap and sticky flag");

    // R6: second jam clears flags and counts
    do_jam();
    check_bufs("R6 cleared");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule